// File: doc/BRIEF.md
# Refresh-Driven System Reset Watchdog

This block watches for a stalled program. Software owns an 8-bit control word: the top bit arms the watchdog, and the low seven bits form a down-counter. A prescaler divides the processor clock and takes one count off the counter at the end of each period. The counter runs whether or not the watchdog is armed. When the watchdog is armed and bit 6 of the counter goes from one to zero, the block drives a fixed-length, active-low reset pulse. This happens when the counter steps from 40h to 3Fh, not when it reaches zero.

Software refreshes the watchdog by writing a value from C0h to FFh. That arms the block, sets bit 6, and places the number of remaining periods in bits 5 to 0. A write also restarts the prescaler, so each timeout is measured from the refresh. A static option input selects hardware mode, in which the watchdog is armed from reset and cannot be disarmed.

Top module: `wdt_timer`

## Requirements
- R1: After a synchronous reset, the control word reads 7Fh when `hw_mode` is 0 and FFh when `hw_mode` is 1. `wdt_rst_n` is high.
- R2: Without a write, the counter (bits 6:0) goes down by one once every PRESCALE clock cycles. The first step comes PRESCALE cycles after reset is released.
- R3: A write loads bits 6:0 from `wr_data[6:0]` and restarts the prescaler, so the next step comes PRESCALE cycles after the write.
- R4: While disarmed, the counter keeps running, wraps from 00h to 7Fh, and passes 40h to 3Fh without any reset pulse.
- R5: While armed, a reset pulse starts in the same cycle the counter steps from 40h to 3Fh. A pulse occurs only while the arm bit (bit 7) reads 1.
- R6: The arm bit is sticky. Writing a 1 to bit 7 arms the block, and a later write with bit 7 at 0 leaves it at 1 while still loading bits 6:0. Only reset clears it.
- R7: In hardware mode the arm bit reads 1 at all times, and the first pulse comes 64·PRESCALE cycles after reset is released.
- R8: `wdt_rst_n` is held low for exactly PULSE_CYCLES clock cycles per pulse.
- R9: A write that clears bit 6 while bit 6 was set, with the block armed after the write, starts a reset pulse at that write.
- R10: A trigger that occurs while a pulse is already active is ignored; the pulse is not extended.
- R11: After writing C0h+n (n from 0 to 63), the pulse starts (n+1)·PRESCALE cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_mode | input | 1 | Static option: 1 forces the watchdog armed |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Control word: {arm, counter[6:0]} |
| wdt_rst_n | output | 1 | Active-low reset pulse |

## Verification
A counter that steps early or late, or a prescaler that fails to restart on a write, moves the start of the reset pulse by whole prescaler periods. It also shows up in `rd_data` within one period. The sweep over all 64 refresh values measures the delay to each pulse edge to the exact cycle. A wrong arm bit shows up on the next read, or as a pulse that appears or goes missing when bit 6 clears. A wrong pulse counter shows up as a low width other than PULSE_CYCLES, including when a second trigger lands inside an active pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W  = 7;
    localparam int WORD_W = CNT_W + 1;
    localparam int SENT_B = CNT_W - 1;

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] count;
    } wdt_ctrl_t;

    // Counter bit 6 going from 1 to 0 is the expiry event.
    function automatic logic sentinel_fall(logic [CNT_W-1:0] before_v,
                                           logic [CNT_W-1:0] after_v);
        return before_v[SENT_B] & ~after_v[SENT_B];
    endfunction

    function automatic wdt_ctrl_t reset_word(logic hw);
        wdt_ctrl_t w;
        w.armed = hw;
        w.count = '1;
        return w;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

    // R2
    period_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tick,
    output wdt_ctrl_t         ctrl_q,
    output logic              expire
);
    wdt_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.count = wr_data[CNT_W-1:0];
            ctrl_d.armed = ctrl_q.armed | wr_data[WORD_W-1];
        end else if (tick) begin
            ctrl_d.count = CNT_W'(ctrl_q.count - 1'b1);
        end
        ctrl_d.armed = ctrl_d.armed | hw_mode;
        expire = ctrl_d.armed & sentinel_fall(ctrl_q.count, ctrl_d.count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= reset_word(hw_mode);
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !tick) |=> $stable(ctrl_q.count));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick) |=> (ctrl_q.count == CNT_W'($past(ctrl_q.count) - 1'b1)));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.armed |=> ctrl_q.armed);

endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic rst_n
);
    localparam int LW = $clog2(LEN + 1);
    localparam logic [LW-1:0] LOAD = LW'(LEN);

    logic [LW-1:0] left_q;

    assign rst_n = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else if (trigger) begin
            left_q <= LOAD;
        end
    end

    // R8
    start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n) |-> $past(trigger));

    // R10
    noretrig_chk: assert property (@(posedge clk) disable iff (rst)
        (left_q != '0) |=> (left_q == LW'($past(left_q) - 1'b1)));

    // R8
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= LOAD);

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRESCALE     = 65536,
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              wdt_rst_n
);
    logic      tick;
    logic      expire;
    wdt_ctrl_t ctrl;

    wdt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_en),
        .tick    (tick)
    );

    wdt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .hw_mode (hw_mode),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .ctrl_q  (ctrl),
        .expire  (expire)
    );

    wdt_rst_pulse #(.LEN(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trigger (expire),
        .rst_n   (wdt_rst_n)
    );

    assign rd_data = ctrl;

    // R5
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        !wdt_rst_n |-> rd_data[WORD_W-1]);

    // R7
    hw_chk: assert property (@(posedge clk) disable iff (rst)
        hw_mode |=> rd_data[WORD_W-1]);

endmodule

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
    localparam int PS = 4;
    localparam int PL = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdt_rst_n;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    wdt_timer #(.PRESCALE(PS), .PULSE_CYCLES(PL)) i_wdt_timer (
        .clk(clk), .rst(rst), .hw_mode(hw_mode), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wdt_rst_n(wdt_rst_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic hw);
        hw_mode = hw;
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic low_width(output int w);
        w = 0;
        while (!wdt_rst_n && w < 100) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        int m;
        int w;
        int hi;
        @(negedge clk);
        do_reset(1'b0);
        // R1 reset value, disarmed
        chk("R1 word", rd_data, 8'h7F);
        chk("R1 rst_n", wdt_rst_n, 1);
        // R2 free-running steps every PS cycles from reset release
        wait_n(PS - 1);
        chk("R2 before step", rd_data, 8'h7F);
        wait_n(1);
        chk("R2 first step", rd_data, 8'h7E);
        wait_n(PS);
        chk("R2 second step", rd_data, 8'h7D);
        // R4 wrap while disarmed
        do_write(8'h01);
        wait_n(PS);
        chk("R4 to zero", rd_data, 8'h00);
        wait_n(PS);
        chk("R4 wrap", rd_data, 8'h7F);
        // R4 crossing 40h->3Fh while disarmed gives no pulse
        do_write(8'h41);
        hi = 1;
        for (int i = 0; i < 3 * PS; i++) begin
            if (!wdt_rst_n) hi = 0;
            @(negedge clk);
        end
        chk("R4 counted past", rd_data, 8'h3E);
        chk("R4 no pulse", hi, 1);
        // R3 write restarts prescaler
        do_write(8'h10);
        wait_n(2);
        do_write(8'h20);
        chk("R3 loaded", rd_data, 8'h20);
        wait_n(PS - 1);
        chk("R3 no early step", rd_data, 8'h20);
        wait_n(1);
        chk("R3 step after restart", rd_data, 8'h1F);
        // R11 / R5 / R8 sweep of all refresh values
        for (int n = 0; n < 64; n++) begin
            do_write(8'hC0 | 8'(n));
            m = 0;
            while (wdt_rst_n && m < 2000) begin
                @(negedge clk);
                m++;
            end
            chk($sformatf("R11 R5 delay n=%0d", n), m, (n + 1) * PS);
            low_width(w);
            chk($sformatf("R8 width n=%0d", n), w, PL);
        end
        // R6 sticky arm bit
        do_write(8'h50);
        chk("R6 arm kept", rd_data, 8'hD0);
        // R9 write clearing bit 6 fires at once
        do_write(8'h3F);
        chk("R9 immediate", wdt_rst_n, 0);
        low_width(w);
        chk("R9 width", w, PL);
        // R10 no retrigger during an active pulse
        do_write(8'hFF);
        do_write(8'h00);
        chk("R10 first pulse", wdt_rst_n, 0);
        do_write(8'h7F);
        do_write(8'h00);
        low_width(w);
        chk("R10 remaining low", w, PL - 2);
        hi = 1;
        for (int i = 0; i < 2 * PS; i++) begin
            if (!wdt_rst_n) hi = 0;
            @(negedge clk);
        end
        chk("R10 not extended", hi, 1);
        // R7 hardware mode
        do_reset(1'b1);
        chk("R1 hw word", rd_data, 8'hFF);
        do_write(8'h7F);
        chk("R7 cannot disarm", rd_data, 8'hFF);
        do_reset(1'b1);
        m = 0;
        while (wdt_rst_n && m < 2000) begin
            @(negedge clk);
            m++;
        end
        chk("R7 hw timeout", m, 64 * PS);
        chk("R7 armed", rd_data[7], 1);
        low_width(w);
        chk("R7 R8 width", w, PL);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule